// File: doc/BRIEF.md
# In-Order Retirement Queue

This block keeps the list of in-flight instructions of a renaming core in program order. Each instruction claims one slot when it issues. The slot holds the destination architectural register, the new physical register and the physical register it replaces. The slot index is handed back to the issuing logic as the instruction's tag. Execution units later report a finished tag, and the block marks that slot's result as ready.

Retirement works only from the oldest slot and retires at most one slot per clock. A slot retires only once its ready mark is already stored, which puts retirement at least one cycle after completion. When a slot retires, the block drives a one-cycle pulse with the slot's tag, its architectural register and the replaced physical register. That physical register goes back to the rename free pool.

Issue logic watches the occupancy count and the full flag. It stops offering instructions while the queue is full.

Top module: `rob_commit_top`

## Requirements
- R1: After reset the queue is empty: `occupancy` is 0, `full` is 0, `commitValid` is 0.
- R2: While not full, an offered allocation is accepted (`allocAccept` = 1). The accepted allocation takes tag `allocTag`. Tags are handed out sequentially modulo DEPTH starting at 0, and occupancy rises by one at the next edge.
- R3: `full` is 1 exactly when occupancy equals DEPTH. While full an offered allocation is refused (`allocAccept` = 0) and occupancy does not grow.
- R4: A completion sampled at a clock edge cannot retire its slot in the cycle it is presented. `commitValid` for that slot is first seen in the following cycle.
- R5: Slots retire strictly in allocation order. A younger slot already marked ready waits while the oldest slot is not ready.
- R6: At most one slot retires per cycle. Ready slots retire in consecutive cycles, one per cycle.
- R7: During a retirement pulse, `commitTag` is the slot index. `commitArch` is the architectural register stored at allocation, and `commitFreePhys` is the replaced physical register stored at allocation.
- R8: A completion naming a slot that is not currently occupied is ignored. The slot is not ready when it is later allocated.
- R9: An accepted allocation and a retirement in the same cycle leave occupancy unchanged.
- R10: Head and tail wrap past slot DEPTH-1 back to slot 0 without losing order or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Issue offers an instruction this cycle |
| allocArch | input | ARCH_W | Destination architectural register |
| allocNewPhys | input | PHYS_W | Physical register newly mapped to the destination |
| allocOldPhys | input | PHYS_W | Physical register previously mapped, freed at retirement |
| allocAccept | output | 1 | Offer taken this cycle |
| allocTag | output | IDX_W | Tag given to the offered instruction |
| doneValid | input | 1 | Completion report this cycle |
| doneTag | input | IDX_W | Tag of the completed instruction |
| commitValid | output | 1 | A slot retires at the end of this cycle |
| commitTag | output | IDX_W | Tag of the retiring slot |
| commitArch | output | ARCH_W | Architectural register of the retiring slot |
| commitNewPhys | output | PHYS_W | Physical register that becomes the committed mapping |
| commitFreePhys | output | PHYS_W | Physical register returned to the free pool |
| occupancy | output | IDX_W+1 | Number of occupied slots |
| full | output | 1 | All slots occupied |

## Verification
The bench builds the block with DEPTH = 4 and the default register widths. With that depth, filling the queue, a refused allocation and pointer wrap-around all occur within a few dozen cycles. The stimulus table runs a fill to full and an early-ready younger slot held behind its elder. It then runs a simultaneous allocate and retire, a stale completion to an emptied slot, and a later reuse of that slot. Together these exercise the order and timing rules against hand-computed expectations.

// File: rtl/rob_commit_pkg.sv
package rob_commit_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic allocWe;     // write a new slot at the tail
    logic commitFire;  // retire the slot at the head
  } rob_strobe_t;
endpackage

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl
  import rob_commit_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             headReady,
  output rob_strobe_t      strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic [PTR_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] headQ, tailQ;

  assign headIdx = headQ[IDX_W-1:0];
  assign tailIdx = tailQ[IDX_W-1:0];
  assign count   = tailQ - headQ;
  assign empty   = (headQ == tailQ);
  assign full    = (headIdx == tailIdx) && (headQ[IDX_W] != tailQ[IDX_W]);

  always_comb begin
    strobe.allocWe    = allocValid && !full;
    strobe.commitFire = headReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
    end else begin
      if (strobe.allocWe)    tailQ <= tailQ + 1'b1;
      if (strobe.commitFire) headQ <= headQ + 1'b1;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= PTR_W'(DEPTH));
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strobe.allocWe);
  p_occ_grows_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.allocWe && !strobe.commitFire) |=> count == $past(count) + 1'b1);
  p_occ_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.allocWe && strobe.commitFire) |=> count == $past(count));
  p_commit_nonempty_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitFire |-> !empty);
  p_single_retire_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitFire |=> headQ == $past(headQ) + 1'b1);
endmodule

// File: rtl/rob_commit_dpath.sv
module rob_commit_dpath
  import rob_commit_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rob_strobe_t       strobe,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [ARCH_W-1:0] allocArch,
  input  logic [PHYS_W-1:0] allocNewPhys,
  input  logic [PHYS_W-1:0] allocOldPhys,
  input  logic              doneValid,
  input  logic [IDX_W-1:0]  doneTag,
  output logic              headReady,
  output logic [ARCH_W-1:0] headArch,
  output logic [PHYS_W-1:0] headNewPhys,
  output logic [PHYS_W-1:0] headOldPhys
);
  logic [DEPTH-1:0]  validQ, readyQ;
  logic [ARCH_W-1:0] archQ [DEPTH];
  logic [PHYS_W-1:0] newQ  [DEPTH];
  logic [PHYS_W-1:0] oldQ  [DEPTH];

  // flag bits: later statements take priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      readyQ <= '0;
    end else begin
      if (doneValid && validQ[doneTag]) readyQ[doneTag] <= 1'b1;
      if (strobe.commitFire) begin
        validQ[headIdx] <= 1'b0;
        readyQ[headIdx] <= 1'b0;
      end
      if (strobe.allocWe) begin
        validQ[tailIdx] <= 1'b1;
        readyQ[tailIdx] <= 1'b0;
      end
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.allocWe) begin
      archQ[tailIdx] <= allocArch;
      newQ[tailIdx]  <= allocNewPhys;
      oldQ[tailIdx]  <= allocOldPhys;
    end
  end

  assign headReady   = validQ[headIdx] && readyQ[headIdx];
  assign headArch    = archQ[headIdx];
  assign headNewPhys = newQ[headIdx];
  assign headOldPhys = oldQ[headIdx];

  p_alloc_fresh_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocWe |=> validQ[$past(tailIdx)] && !readyQ[$past(tailIdx)]);
  p_retire_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitFire |=> !validQ[$past(headIdx)]);
  p_ignore_stale_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !validQ[doneTag]) |=> !readyQ[$past(doneTag)]);
  p_done_marks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && validQ[doneTag] && !(strobe.commitFire && doneTag == headIdx))
      |=> readyQ[$past(doneTag)]);
endmodule

// File: rtl/rob_commit_top.sv
module rob_commit_top
  import rob_commit_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ARCH_W = 5,
  parameter int PHYS_W = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [ARCH_W-1:0] allocArch,
  input  logic [PHYS_W-1:0] allocNewPhys,
  input  logic [PHYS_W-1:0] allocOldPhys,
  output logic              allocAccept,
  output logic [IDX_W-1:0]  allocTag,
  input  logic              doneValid,
  input  logic [IDX_W-1:0]  doneTag,
  output logic              commitValid,
  output logic [IDX_W-1:0]  commitTag,
  output logic [ARCH_W-1:0] commitArch,
  output logic [PHYS_W-1:0] commitNewPhys,
  output logic [PHYS_W-1:0] commitFreePhys,
  output logic [IDX_W:0]    occupancy,
  output logic              full
);
  rob_strobe_t      strobe;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic             headReady, empty;

  rob_commit_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .headReady(headReady),
    .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .count(occupancy), .full(full), .empty(empty)
  );

  rob_commit_dpath #(.DEPTH(DEPTH), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx),
    .allocArch(allocArch), .allocNewPhys(allocNewPhys), .allocOldPhys(allocOldPhys),
    .doneValid(doneValid), .doneTag(doneTag), .headReady(headReady),
    .headArch(commitArch), .headNewPhys(commitNewPhys), .headOldPhys(commitFreePhys)
  );

  assign allocAccept = strobe.allocWe;
  assign allocTag    = tailIdx;
  assign commitValid = strobe.commitFire;
  assign commitTag   = headIdx;

  p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !commitValid && occupancy == '0);
endmodule

// File: tb/rob_commit_top_tb_top.sv
`timescale 1ns/1ps
module rob_commit_top_tb_top;
  localparam int DEPTH = 4;
  localparam int ARCH_W = 5;
  localparam int PHYS_W = 6;
  localparam int IDX_W = 2;
  localparam int NVEC = 19;

  typedef struct packed {
    logic       av;  logic [4:0] arch; logic [5:0] np; logic [5:0] op;
    logic       dv;  logic [1:0] dt;
    logic       acc; logic [1:0] atag;
    logic       cv;  logic [1:0] ctag; logic [4:0] carch; logic [5:0] cfree;
    logic [2:0] cnt; logic full;
  } vec_t;

  // per cycle: drive, then expected outputs seen in that cycle
  localparam vec_t VEC [NVEC] = '{
    '{1,1,10,20, 0,0, 1,0, 0,0,0,0, 0,0}, // c0 R2
    '{1,2,11,21, 0,0, 1,1, 0,0,0,0, 1,0}, // c1 R2
    '{1,3,12,22, 1,1, 1,2, 0,0,0,0, 2,0}, // c2 younger done
    '{1,4,13,23, 0,0, 1,3, 0,0,0,0, 3,0}, // c3 R5 wait
    '{1,5,14,24, 0,0, 0,0, 0,0,0,0, 4,1}, // c4 R3 refused
    '{0,0,0,0,   1,0, 0,0, 0,0,0,0, 4,1}, // c5 R4 not yet
    '{0,0,0,0,   0,0, 0,0, 1,0,1,20,4,1}, // c6 R4 R7
    '{1,6,15,25, 0,0, 1,0, 1,1,2,21,3,0}, // c7 R6 R9
    '{0,0,0,0,   1,2, 0,0, 0,0,0,0, 3,0}, // c8
    '{0,0,0,0,   1,1, 0,0, 1,2,3,22,3,0}, // c9 R8 stale
    '{1,7,16,26, 0,0, 1,1, 0,0,0,0, 2,0}, // c10 reuse slot 1
    '{0,0,0,0,   1,3, 0,0, 0,0,0,0, 3,0}, // c11
    '{0,0,0,0,   1,0, 0,0, 1,3,4,23,3,0}, // c12
    '{0,0,0,0,   0,0, 0,0, 1,0,6,25,2,0}, // c13 R10 wrap
    '{0,0,0,0,   0,0, 0,0, 0,0,0,0, 1,0}, // c14 R8 slot1 not ready
    '{0,0,0,0,   1,1, 0,0, 0,0,0,0, 1,0}, // c15
    '{0,0,0,0,   0,0, 0,0, 1,1,7,26,1,0}, // c16
    '{0,0,0,0,   0,0, 0,0, 0,0,0,0, 0,0}, // c17
    '{0,0,0,0,   0,0, 0,0, 0,0,0,0, 0,0}  // c18
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, doneValid = 0;
  logic [ARCH_W-1:0] allocArch = '0;
  logic [PHYS_W-1:0] allocNewPhys = '0, allocOldPhys = '0;
  logic [IDX_W-1:0] doneTag = '0;
  logic allocAccept, commitValid, full;
  logic [IDX_W-1:0] allocTag, commitTag;
  logic [ARCH_W-1:0] commitArch;
  logic [PHYS_W-1:0] commitNewPhys, commitFreePhys;
  logic [IDX_W:0] occupancy;
  int applied = 0, bad = 0;

  always #10 clk = ~clk;

  rob_commit_top #(.DEPTH(DEPTH), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) dut_i (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocArch(allocArch),
    .allocNewPhys(allocNewPhys), .allocOldPhys(allocOldPhys),
    .allocAccept(allocAccept), .allocTag(allocTag),
    .doneValid(doneValid), .doneTag(doneTag),
    .commitValid(commitValid), .commitTag(commitTag), .commitArch(commitArch),
    .commitNewPhys(commitNewPhys), .commitFreePhys(commitFreePhys),
    .occupancy(occupancy), .full(full)
  );

  task automatic check(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check({req, " occupancy"}, int'(occupancy), 0);
    check({req, " full"}, int'(full), 0);
    check({req, " commitValid"}, int'(commitValid), 0);
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check_idle("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");
    for (int i = 0; i < NVEC; i++) begin
      allocValid = VEC[i].av; allocArch = VEC[i].arch;
      allocNewPhys = VEC[i].np; allocOldPhys = VEC[i].op;
      doneValid = VEC[i].dv; doneTag = VEC[i].dt;
      #5;
      check("R2/R3 accept", int'(allocAccept), int'(VEC[i].acc));
      if (VEC[i].av) check("R2/R10 tag", int'(allocTag), int'(VEC[i].atag));
      check("R4/R5/R6 commitValid", int'(commitValid), int'(VEC[i].cv));
      if (VEC[i].cv) begin
        check("R7 commitTag", int'(commitTag), int'(VEC[i].ctag));
        check("R7 commitArch", int'(commitArch), int'(VEC[i].carch));
        check("R7 commitFreePhys", int'(commitFreePhys), int'(VEC[i].cfree));
      end
      check("R9 occupancy", int'(occupancy), int'(VEC[i].cnt));
      check("R3 full", int'(full), int'(VEC[i].full));
      @(negedge clk);
    end
    allocValid = 1'b0; doneValid = 1'b0;
    // refill partly, then reset mid-run
    allocValid = 1'b1;
    repeat (3) @(negedge clk);
    allocValid = 1'b0;
    #5 check("R2 occupancy before reset", int'(occupancy), 3);
    rstN = 1'b0;
    #2 check_idle("R1 mid-run reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check_idle("R1 released");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule